// File: doc/BRIEF.md
# Code/Data/Stack Translation-Unit Steering

This block sits between the CPU's memory interface and three address translation units. The units handle code, data and stack. For every memory reference it decides which unit should translate the address, and it pulls that unit's active-low select line. Instruction fetches always go to the code unit. Any other reference is split between data and stack by a programmable boundary. The upper byte of the 16-bit logical offset is compared against an 8-bit break value. Addresses below the break are data, and addresses at or above it are stack.

Two break values are kept, one for each privilege mode. The system-mode break lives at I/O port 0xFFC9 and the normal-mode break at I/O port 0xFFCB. Both are written and read back through a plain I/O port. The block also supplies the segment descriptor index that the units use for non-segmented operation: index 0 in system mode and index 63 in normal mode. Address translation, descriptor contents and violation handling sit outside the block.

Top module: `mmu_steer_top`

## Requirements
- R1: During a valid memory request with `progFetch` high, only `codeSelN` is low. `dataSelN` and `stackSelN` stay high.
- R2: During a valid non-fetch memory request, if `logAddr[15:8]` is strictly below the active break value, only `dataSelN` is low.
- R3: During a valid non-fetch memory request, if `logAddr[15:8]` is greater than or equal to the active break value, only `stackSelN` is low. The equal case goes to stack.
- R4: The active break value is the system break when `sysMode` is 1 and the normal break when `sysMode` is 0.
- R5: On a rising clock edge with `ioWr` high, `ioWrData` is stored as follows:
  - into the system break when `ioAddr` is 16'hFFC9;
  - into the normal break when `ioAddr` is 16'hFFCB;
  - for any other `ioAddr`, neither break changes.
- R6: A memory request is valid only when `memReq` is 1 and both `ioWr` and `ioRd` are 0. In every other cycle all three selects are high.
- R7: After reset both break values are 0x00, so every valid non-fetch reference selects the stack unit until a break is programmed.
- R8: `descIdx` is 0 when `sysMode` is 1 and 63 when `sysMode` is 0.
- R9: With `ioRd` high, `ioRdData` shows the following; with `ioRd` low it is 0:
  - the system break when `ioAddr` is 16'hFFC9;
  - the normal break when `ioAddr` is 16'hFFCB;
  - 0 for any other address.
- R10: The selects and readback are combinational from the current inputs. A break written at one edge governs the steering from the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| logAddr | input | 16 | Logical offset of the current memory reference |
| progFetch | input | 1 | 1 when the reference is an instruction fetch |
| sysMode | input | 1 | 1 = system mode, 0 = normal mode |
| memReq | input | 1 | Memory request strobe |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data (break readback) |
| codeSelN | output | 1 | Active-low select of the code unit |
| dataSelN | output | 1 | Active-low select of the data unit |
| stackSelN | output | 1 | Active-low select of the stack unit |
| descIdx | output | 6 | Segment descriptor index for the units |

## Verification
The bench targets the boundary byte. An address whose upper byte equals the break must reach the stack unit, and one just below it must reach the data unit; a comparator with the wrong sense or `<=` swaps exactly these cases. It also crosses the two modes with two distinct break values, so a design that uses one register for both modes, or picks the wrong one, sends a reference to the wrong unit. Writes to a neighbouring port (0xFFCA) are checked through readback, which would expose a loose address decode. Requests that overlap an I/O strobe are checked too, and a design that ignores those strobes would raise a select.

// File: rtl/mmu_steer_pkg.sv
package mmu_steer_pkg;

  typedef struct packed {
    logic wrSys;     // load system break
    logic wrNorm;    // load normal break
    logic rdSys;     // drive system break on readback
    logic rdNorm;    // drive normal break on readback
    logic memValid;  // qualified memory reference
    logic fetch;     // reference is an instruction fetch
    logic useSys;    // compare against the system break
  } steerStrobes_t;

endpackage

// File: rtl/mmu_steer_ctl.sv
module mmu_steer_ctl
  import mmu_steer_pkg::*;
#(
  parameter int          IO_W      = 16,
  parameter logic [15:0] SYS_PORT  = 16'hFFC9,
  parameter logic [15:0] NORM_PORT = 16'hFFCB
) (
  input  logic            memReq,
  input  logic            progFetch,
  input  logic            sysMode,
  input  logic            ioWr,
  input  logic            ioRd,
  input  logic [IO_W-1:0] ioAddr,
  output steerStrobes_t   strobes
);

  logic hitSys;
  logic hitNorm;
  logic ioBusy;

  always_comb begin
    hitSys  = (ioAddr == SYS_PORT[IO_W-1:0]);
    hitNorm = (ioAddr == NORM_PORT[IO_W-1:0]);
    ioBusy  = ioWr | ioRd;

    strobes.wrSys    = ioWr & hitSys;
    strobes.wrNorm   = ioWr & hitNorm;
    strobes.rdSys    = ioRd & hitSys;
    strobes.rdNorm   = ioRd & hitNorm;
    strobes.memValid = memReq & ~ioBusy;
    strobes.fetch    = progFetch;
    strobes.useSys   = sysMode;
  end

endmodule

// File: rtl/mmu_steer_dp.sv
module mmu_steer_dp
  import mmu_steer_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BRK_W    = 8,
  parameter int IDX_W    = 6,
  parameter int SYS_IDX  = 0,
  parameter int USER_IDX = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerStrobes_t     strobes,
  input  logic [ADDR_W-1:0] logAddr,
  input  logic [BRK_W-1:0]  ioWrData,
  output logic [BRK_W-1:0]  ioRdData,
  output logic              codeSelN,
  output logic              dataSelN,
  output logic              stackSelN,
  output logic [IDX_W-1:0]  descIdx
);

  localparam int HI_LSB = ADDR_W - BRK_W;
  localparam int N_BRK  = 2;
  localparam int SYS_B  = 0;
  localparam int NORM_B = 1;

  logic [BRK_W-1:0] brkReg [N_BRK];
  logic [N_BRK-1:0] brkLoad;
  logic [BRK_W-1:0] activeBrk;
  logic [BRK_W-1:0] hiByte;
  logic             belowBrk;

  assign brkLoad[SYS_B]  = strobes.wrSys;
  assign brkLoad[NORM_B] = strobes.wrNorm;

  for (genvar b = 0; b < N_BRK; b++) begin : g_brk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          brkReg[b] <= '0;
      else if (brkLoad[b]) brkReg[b] <= ioWrData;
    end
  end

  always_comb begin
    hiByte    = logAddr[ADDR_W-1:HI_LSB];
    activeBrk = strobes.useSys ? brkReg[SYS_B] : brkReg[NORM_B];
    belowBrk  = (hiByte < activeBrk);

    codeSelN  = 1'b1;
    dataSelN  = 1'b1;
    stackSelN = 1'b1;
    if (strobes.memValid) begin
      if (strobes.fetch)  codeSelN  = 1'b0;
      else if (belowBrk)  dataSelN  = 1'b0;
      else                stackSelN = 1'b0;
    end

    descIdx = strobes.useSys ? IDX_W'(SYS_IDX) : IDX_W'(USER_IDX);

    ioRdData = '0;
    if (strobes.rdSys)       ioRdData = brkReg[SYS_B];
    else if (strobes.rdNorm) ioRdData = brkReg[NORM_B];
  end

endmodule

// File: rtl/mmu_steer_top.sv
module mmu_steer_top
  import mmu_steer_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          BRK_W     = 8,
  parameter int          IDX_W     = 6,
  parameter int          IO_W      = 16,
  parameter logic [15:0] SYS_PORT  = 16'hFFC9,
  parameter logic [15:0] NORM_PORT = 16'hFFCB,
  parameter int          SYS_IDX   = 0,
  parameter int          USER_IDX  = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] logAddr,
  input  logic              progFetch,
  input  logic              sysMode,
  input  logic              memReq,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [IO_W-1:0]   ioAddr,
  input  logic [BRK_W-1:0]  ioWrData,
  output logic [BRK_W-1:0]  ioRdData,
  output logic              codeSelN,
  output logic              dataSelN,
  output logic              stackSelN,
  output logic [IDX_W-1:0]  descIdx
);

  steerStrobes_t strobes;

  mmu_steer_ctl #(
    .IO_W(IO_W), .SYS_PORT(SYS_PORT), .NORM_PORT(NORM_PORT)
  ) ctl_i (
    .memReq(memReq), .progFetch(progFetch), .sysMode(sysMode),
    .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr), .strobes(strobes)
  );

  mmu_steer_dp #(
    .ADDR_W(ADDR_W), .BRK_W(BRK_W), .IDX_W(IDX_W),
    .SYS_IDX(SYS_IDX), .USER_IDX(USER_IDX)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .logAddr(logAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .codeSelN(codeSelN),
    .dataSelN(dataSelN), .stackSelN(stackSelN), .descIdx(descIdx)
  );

endmodule

// File: rtl/mmu_steer_chk.sv
module mmu_steer_chk #(
  parameter int          BRK_W     = 8,
  parameter int          IDX_W     = 6,
  parameter int          IO_W      = 16,
  parameter logic [15:0] SYS_PORT  = 16'hFFC9,
  parameter int          SYS_IDX   = 0,
  parameter int          USER_IDX  = 63
) (
  input logic             clk,
  input logic             rstN,
  input logic             progFetch,
  input logic             sysMode,
  input logic             memReq,
  input logic             ioWr,
  input logic             ioRd,
  input logic [IO_W-1:0]  ioAddr,
  input logic [BRK_W-1:0] ioWrData,
  input logic [BRK_W-1:0] ioRdData,
  input logic             codeSelN,
  input logic             dataSelN,
  input logic             stackSelN,
  input logic [IDX_W-1:0] descIdx
);

  logic [2:0] selAct;
  assign selAct = ~{codeSelN, dataSelN, stackSelN};

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selAct));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq || ioWr || ioRd) |-> (selAct == 3'b000));

  // R1
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !ioWr && !ioRd && progFetch) |-> (selAct == 3'b100));

  // R3
  nonfetch_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !ioWr && !ioRd && !progFetch) |-> ($countones(selAct[1:0]) == 1));

  // R8
  desc_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    descIdx == (sysMode ? IDX_W'(SYS_IDX) : IDX_W'(USER_IDX)));

  // R5
  sys_wr_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == SYS_PORT[IO_W-1:0])
      |=> ((ioRd && !ioWr && ioAddr == SYS_PORT[IO_W-1:0]) -> (ioRdData == $past(ioWrData))));

endmodule

bind mmu_steer_top mmu_steer_chk #(
  .BRK_W(BRK_W), .IDX_W(IDX_W), .IO_W(IO_W),
  .SYS_PORT(SYS_PORT), .SYS_IDX(SYS_IDX), .USER_IDX(USER_IDX)
) chk_i (
  .clk(clk), .rstN(rstN), .progFetch(progFetch), .sysMode(sysMode),
  .memReq(memReq), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .codeSelN(codeSelN),
  .dataSelN(dataSelN), .stackSelN(stackSelN), .descIdx(descIdx)
);

// File: tb/mmu_steer_tb.sv
module mmu_steer_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] logAddr = '0;
  logic        progFetch = 1'b0;
  logic        sysMode = 1'b1;
  logic        memReq = 1'b0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        codeSelN, dataSelN, stackSelN;
  logic [5:0]  descIdx;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int sysBrk = 0;
  int normBrk = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  mmu_steer_top dut_i (
    .clk(clk), .rstN(rstN), .logAddr(logAddr), .progFetch(progFetch),
    .sysMode(sysMode), .memReq(memReq), .ioWr(ioWr), .ioRd(ioRd),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .codeSelN(codeSelN), .dataSelN(dataSelN), .stackSelN(stackSelN),
    .descIdx(descIdx)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // compare at negedge against the behavioural model, then advance the model at posedge
  task automatic tick(input string req);
    int brk, hi;
    logic [2:0] expSel;
    logic [7:0] expRd;
    int expIdx;
    @(negedge clk);
    vectors++;
    brk = sysMode ? sysBrk : normBrk;
    hi  = int'(logAddr[15:8]);
    if (!rstN || !memReq || ioWr || ioRd) expSel = 3'b111;
    else if (progFetch)                    expSel = 3'b011;
    else if (hi < brk)                     expSel = 3'b101;
    else                                   expSel = 3'b110;
    expRd = 8'h00;
    if (ioRd && ioAddr == 16'hFFC9)      expRd = 8'(sysBrk);
    else if (ioRd && ioAddr == 16'hFFCB) expRd = 8'(normBrk);
    expIdx = sysMode ? 0 : 63;
    if ({codeSelN, dataSelN, stackSelN} !== expSel) begin
      miscompares++;
      $display("FAIL %s sel: got %b exp %b", req, {codeSelN, dataSelN, stackSelN}, expSel);
    end
    if (ioRdData !== expRd) begin
      miscompares++;
      $display("FAIL %s rd: got %h exp %h", req, ioRdData, expRd);
    end
    if (int'(descIdx) != expIdx) begin
      miscompares++;
      $display("FAIL %s idx: got %0d exp %0d", req, descIdx, expIdx);
    end
    @(posedge clk);
    if (rstN && ioWr && ioAddr == 16'hFFC9) sysBrk = int'(ioWrData);
    if (rstN && ioWr && ioAddr == 16'hFFCB) normBrk = int'(ioWrData);
    #1;
  endtask

  task automatic mem(input bit sys, input bit fetch, input logic [15:0] a, input string req);
    memReq = 1; ioWr = 0; ioRd = 0; sysMode = sys; progFetch = fetch; logAddr = a;
    tick(req);
    memReq = 0;
  endtask

  task automatic iow(input logic [15:0] p, input logic [7:0] d, input string req);
    memReq = 0; ioRd = 0; ioWr = 1; ioAddr = p; ioWrData = d;
    tick(req);
    ioWr = 0;
  endtask

  task automatic ior(input logic [15:0] p, input string req);
    memReq = 0; ioWr = 0; ioRd = 1; ioAddr = p;
    tick(req);
    ioRd = 0;
  endtask

  initial begin
    #(5.0 * 50000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick("R7 reset");
    tick("R7 reset");
    #1 rstN = 1;
    @(posedge clk); #1;
    mem(1, 0, 16'h0000, "R7 reset break -> stack");
    mem(0, 0, 16'h0012, "R7 reset normal break -> stack");
    ior(16'hFFC9, "R7 sys readback zero");
    iow(16'hFFC9, 8'h80, "R5 sys write");
    mem(1, 0, 16'h7FFF, "R10 R2 below break -> data");
    mem(1, 0, 16'h8000, "R3 equal -> stack");
    mem(1, 0, 16'h80FF, "R3 above -> stack");
    mem(1, 1, 16'h7000, "R1 fetch -> code");
    mem(0, 0, 16'h1234, "R4 normal break still 0 -> stack");
    iow(16'hFFCB, 8'h40, "R5 norm write");
    mem(0, 0, 16'h3FFF, "R4 R2 normal below -> data");
    mem(0, 0, 16'h4000, "R4 R3 normal equal -> stack");
    mem(1, 0, 16'h7000, "R4 system uses 0x80 -> data");
    mem(0, 1, 16'hFFFF, "R1 R8 user fetch");
    iow(16'hFFCA, 8'h11, "R5 stray port write");
    ior(16'hFFC9, "R5 R9 sys unchanged");
    ior(16'hFFCB, "R5 R9 norm unchanged");
    ior(16'h00C9, "R9 other port reads 0");
    // R6: request overlapping I/O strobes
    memReq = 1; progFetch = 0; logAddr = 16'h0100; ioWr = 1; ioAddr = 16'h0000;
    tick("R6 req with ioWr");
    ioWr = 0; ioRd = 1;
    tick("R6 req with ioRd");
    ioRd = 0; memReq = 0;
    tick("R6 no request");
    iow(16'hFFC9, 8'hFF, "R5 sys write FF");
    mem(1, 0, 16'hFEFF, "R10 R2 below FF -> data");
    mem(1, 0, 16'hFFFF, "R3 equal FF -> stack");
    for (int i = 0; i < 400; i++) begin
      int kind = int'($urandom_range(0, 9));
      memReq = ($urandom_range(0, 7) != 0);
      ioWr = (kind == 0);
      ioRd = (kind == 1);
      ioAddr = ($urandom_range(0, 1) != 0) ? 16'hFFC9 + 16'($urandom_range(0, 3)) : 16'($urandom);
      ioWrData = 8'($urandom);
      sysMode = $urandom_range(0, 1) != 0;
      progFetch = ($urandom_range(0, 3) == 0);
      logAddr = 16'($urandom);
      tick("R2 R3 R4 R9 random");
    end
    finish_run();
  end

endmodule